// File: doc/BRIEF.md
# Configurable PLD Output Macrocell Bank

This block is the output stage of a small programmable logic device. Each cell receives one sum-of-products term from the logic array and settles what the pin shows. Two configuration bits choose the pin's source, a flip-flop or the raw sum term, and its sense, true or complemented. A dedicated product term per cell enables the pin driver. A feedback line carries each cell's state back into the array.

All flip-flops in the bank share one synchronous set term and one asynchronous reset term. Both act on the stored bit ahead of the polarity stage. A test preload strobe can write any chosen pattern into every flip-flop on one clock edge. When its driver is disabled, a combinational cell's pin works as an extra array input: feedback then carries whatever level an outside source places on the pad. The bank is built from `NCELL` identical cells.

Top module: `pld_mc_bank`

## Requirements
- R1: With `cfg_reg[i]`=0 (combinational), `pin_out[i]` follows `sop[i]` in the same cycle, through the polarity stage, with no clock edge needed.
- R2: With `cfg_reg[i]`=1 (registered), the flip-flop takes `sop[i]` on each rising clock edge, and `pin_out[i]` shows the stored bit through the polarity stage.
- R3: `cfg_inv[i]`=1 makes `pin_out[i]` the complement of the selected source. `cfg_inv[i]`=0 passes it unchanged. This holds in both modes.
- R4: `pin_oe[i]` equals the cell's own enable term `oe_term[i]`. Disabling one cell leaves the drive of the others unchanged.
- R5: When `sset`=1 and no preload is requested, every flip-flop holds 1 after the next rising edge, whatever the sum terms are.
- R6: While `arst`=1, every flip-flop is 0 at once, without a clock edge. Reset wins over preload, set and data.
- R7: Set and reset act ahead of polarity. After a set, a registered inverting cell drives 0. After a reset, it drives 1.
- R8: When `pl_en`=1 and `arst`=0, each flip-flop takes `pl_data[i]` on the next rising edge. Preload wins over set and over the sum term.
- R9: In registered mode, `fb[i]` is the stored bit, uninverted, whatever the polarity and the enable are.
- R10: In combinational mode, `fb[i]` is the pad level `pin_in[i]`. With the driver disabled, this level comes from outside, so the pin serves as an input.
- R11: Set, reset and preload reach all cells in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cell flip-flops |
| arst | input | 1 | Shared asynchronous reset term, active high |
| sset | input | 1 | Shared synchronous set term, active high |
| pl_en | input | 1 | Test preload strobe |
| pl_data | input | NCELL | Preload pattern, one bit per cell |
| sop | input | NCELL | Sum-of-products term per cell |
| oe_term | input | NCELL | Driver enable product term per cell |
| cfg_reg | input | NCELL | 1 = registered source, 0 = combinational |
| cfg_inv | input | NCELL | 1 = inverted pin level |
| pin_in | input | NCELL | Level seen at each pad |
| pin_out | output | NCELL | Value each pad driver would drive |
| pin_oe | output | NCELL | Pad driver enable |
| fb | output | NCELL | Feedback into the logic array |

## Verification
The bench builds the bank with `NCELL`=4. Four cells are enough to give each cell a different mix of mode, polarity and enable within one pattern, so one stimulus covers several configurations at once. With that width, shared set, reset and preload can be seen reaching cells of both polarities in the same cycle. The external pad drive can disagree with the disabled cells, which shows input reuse on combinational cells against register feedback on the rest. Linting also elaborates the default of 10 cells.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_SET  = 2'd1,
    SRC_LOAD = 2'd2
  } load_src_t;

  // choose what the flip-flop takes at the next edge (reset handled apart)
  function automatic load_src_t f_src(input logic pl_en, input logic sset);
    if (pl_en)     return SRC_LOAD;
    else if (sset) return SRC_SET;
    else           return SRC_DATA;
  endfunction

  function automatic logic f_next(input load_src_t src, input logic pl_d,
                                  input logic d);
    unique case (src)
      SRC_LOAD: return pl_d;
      SRC_SET:  return 1'b1;
      default:  return d;
    endcase
  endfunction

  function automatic logic f_pin(input logic reg_mode, input logic invert,
                                 input logic q, input logic sop);
    logic pick;
    pick = reg_mode ? q : sop;
    return invert ? ~pick : pick;
  endfunction

  function automatic logic f_fb(input logic reg_mode, input logic q,
                                input logic pad);
    return reg_mode ? q : pad;
  endfunction

endpackage

// File: rtl/pld_mc_store.sv
module pld_mc_store
  import pld_mc_pkg::*;
(
  input  logic      clk,
  input  logic      arst,
  input  logic      sset,
  input  logic      pl_en,
  input  logic      pl_d,
  input  logic      d,
  output logic      q,
  output load_src_t src
);

  logic nxt;

  always_comb begin
    src = f_src(pl_en, sset);
    nxt = f_next(src, pl_d, d);
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) q <= 1'b0;
    else      q <= nxt;
  end

endmodule

// File: rtl/pld_mc_route.sv
module pld_mc_route
  import pld_mc_pkg::*;
(
  input  logic reg_mode,
  input  logic invert,
  input  logic q,
  input  logic sop,
  input  logic oe_term,
  input  logic pad_in,
  output logic pin_out,
  output logic pin_oe,
  output logic fb
);

  always_comb begin
    pin_out = f_pin(reg_mode, invert, q, sop);
    pin_oe  = oe_term;
    fb      = f_fb(reg_mode, q, pad_in);
  end

endmodule

// File: rtl/pld_mc_cell.sv
module pld_mc_cell
  import pld_mc_pkg::*;
(
  input  logic      clk,
  input  logic      arst,
  input  logic      sset,
  input  logic      pl_en,
  input  logic      pl_d,
  input  logic      sop,
  input  logic      oe_term,
  input  logic      reg_mode,
  input  logic      invert,
  input  logic      pad_in,
  output logic      pin_out,
  output logic      pin_oe,
  output logic      fb,
  output logic      q,
  output load_src_t src
);

  pld_mc_store u_store (
    .clk   (clk),
    .arst  (arst),
    .sset  (sset),
    .pl_en (pl_en),
    .pl_d  (pl_d),
    .d     (sop),
    .q     (q),
    .src   (src)
  );

  pld_mc_route u_route (
    .reg_mode (reg_mode),
    .invert   (invert),
    .q        (q),
    .sop      (sop),
    .oe_term  (oe_term),
    .pad_in   (pad_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb       (fb)
  );

endmodule

// File: rtl/pld_mc_bank.sv
module pld_mc_bank
  import pld_mc_pkg::*;
#(
  parameter int NCELL = 10
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             sset,
  input  logic             pl_en,
  input  logic [NCELL-1:0] pl_data,
  input  logic [NCELL-1:0] sop,
  input  logic [NCELL-1:0] oe_term,
  input  logic [NCELL-1:0] cfg_reg,
  input  logic [NCELL-1:0] cfg_inv,
  input  logic [NCELL-1:0] pin_in,
  output logic [NCELL-1:0] pin_out,
  output logic [NCELL-1:0] pin_oe,
  output logic [NCELL-1:0] fb
);

  localparam int LAST = NCELL - 1;

  // named internal events, watched by the bound checker
  logic [NCELL-1:0] reg_q;
  logic [NCELL-1:0] set_hit;
  logic [NCELL-1:0] load_hit;
  load_src_t        cell_src [NCELL];

  for (genvar i = 0; i <= LAST; i++) begin : g_cell
    pld_mc_cell u_cell (
      .clk      (clk),
      .arst     (arst),
      .sset     (sset),
      .pl_en    (pl_en),
      .pl_d     (pl_data[i]),
      .sop      (sop[i]),
      .oe_term  (oe_term[i]),
      .reg_mode (cfg_reg[i]),
      .invert   (cfg_inv[i]),
      .pad_in   (pin_in[i]),
      .pin_out  (pin_out[i]),
      .pin_oe   (pin_oe[i]),
      .fb       (fb[i]),
      .q        (reg_q[i]),
      .src      (cell_src[i])
    );
    assign set_hit[i]  = (cell_src[i] == SRC_SET);
    assign load_hit[i] = (cell_src[i] == SRC_LOAD);
  end

endmodule

// File: rtl/pld_mc_bank_chk.sv
module pld_mc_bank_chk #(
  parameter int NCELL = 10
) (
  input logic             clk,
  input logic             arst,
  input logic             sset,
  input logic             pl_en,
  input logic [NCELL-1:0] pl_data,
  input logic [NCELL-1:0] sop,
  input logic [NCELL-1:0] cfg_reg,
  input logic [NCELL-1:0] cfg_inv,
  input logic [NCELL-1:0] pin_in,
  input logic [NCELL-1:0] pin_out,
  input logic [NCELL-1:0] fb,
  input logic [NCELL-1:0] reg_q,
  input logic [NCELL-1:0] set_hit,
  input logic [NCELL-1:0] load_hit
);

  // R2: plain data capture on the edge
  a_r2_capture: assert property (@(posedge clk) disable iff (arst)
    (!pl_en && !sset) |=> (reg_q == $past(sop)));

  // R5 / R11: shared set fills every cell
  a_r5_set_all: assert property (@(posedge clk) disable iff (arst)
    (set_hit != '0) |=> (reg_q == {NCELL{1'b1}}));

  // R8: preload writes the pattern
  a_r8_preload: assert property (@(posedge clk) disable iff (arst)
    (load_hit != '0) |=> (reg_q == $past(pl_data)));

  // R3 / R7: registered pins show the state through polarity
  a_r3_polarity: assert property (@(posedge clk) disable iff (arst)
    (((pin_out ^ cfg_inv) & cfg_reg) == (reg_q & cfg_reg)));

  // R9: registered feedback is the stored bit
  a_r9_fb_reg: assert property (@(posedge clk) disable iff (arst)
    ((fb & cfg_reg) == (reg_q & cfg_reg)));

  // R10: combinational feedback is the pad
  a_r10_fb_comb: assert property (@(posedge clk) disable iff (arst)
    ((fb & ~cfg_reg) == (pin_in & ~cfg_reg)));

  // R6: asynchronous clear holds while the term is high
  always @(negedge clk) begin
    if (arst) begin
      a_r6_reset: assert (reg_q == '0);
    end
  end

endmodule

bind pld_mc_bank pld_mc_bank_chk #(.NCELL(NCELL)) u_chk (
  .clk      (clk),
  .arst     (arst),
  .sset     (sset),
  .pl_en    (pl_en),
  .pl_data  (pl_data),
  .sop      (sop),
  .cfg_reg  (cfg_reg),
  .cfg_inv  (cfg_inv),
  .pin_in   (pin_in),
  .pin_out  (pin_out),
  .fb       (fb),
  .reg_q    (reg_q),
  .set_hit  (set_hit),
  .load_hit (load_hit)
);

// File: tb/pld_mc_bank_tb_top.sv
module pld_mc_bank_tb_top;

  localparam int N = 4;

  typedef struct {
    logic [N-1:0] pin;
    logic [N-1:0] oe;
    logic [N-1:0] fb;
    string        req;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic         arst = 1'b1, sset = 1'b0, pl_en = 1'b0;
  logic [N-1:0] pl_data = '0, sop = '0, oe_term = '0;
  logic [N-1:0] cfg_reg = '0, cfg_inv = '0, ext = '0;
  logic [N-1:0] pin_in, pin_out, pin_oe, fb;

  // pad model: driven pins read back their own level
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  pld_mc_bank #(.NCELL(N)) dut_i (
    .clk(clk), .arst(arst), .sset(sset), .pl_en(pl_en), .pl_data(pl_data),
    .sop(sop), .oe_term(oe_term), .cfg_reg(cfg_reg), .cfg_inv(cfg_inv),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  int   total = 0, bad = 0;
  exp_t sb [$];
  logic [N-1:0] mq = '0;   // bench model of stored bits

  task automatic apply(input logic a, input logic s, input logic pe,
                       input logic [N-1:0] pd, input logic [N-1:0] d,
                       input logic [N-1:0] oe, input logic [N-1:0] rg,
                       input logic [N-1:0] iv, input logic [N-1:0] ex,
                       input string req);
    exp_t e;
    logic [N-1:0] pad;
    @(negedge clk);
    arst = a; sset = s; pl_en = pe; pl_data = pd; sop = d;
    oe_term = oe; cfg_reg = rg; cfg_inv = iv; ext = ex;
    if (a) mq = '0;
    for (int i = 0; i < N; i++) begin
      e.pin[i] = (rg[i] ? mq[i] : d[i]) ^ iv[i];
      pad[i]   = oe[i] ? e.pin[i] : ex[i];
      e.fb[i]  = rg[i] ? mq[i] : pad[i];
    end
    e.oe  = oe;
    e.req = req;
    sb.push_back(e);
    if (a)       mq = '0;
    else if (pe) mq = pd;
    else if (s)  mq = '1;
    else         mq = d;
  endtask

  task automatic cmp(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // monitor: sample between the driving negedge and the next posedge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.req, "pin_out", pin_out, e.pin);
        cmp(e.req, "pin_oe",  pin_oe,  e.oe);
        cmp(e.req, "fb",      fb,      e.fb);
      end
    end
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R6 reset state, all registered, true polarity
    apply(1,0,0,4'h0,4'hF,4'hF,4'hF,4'h0,4'h0,"R6");
    // R2 capture and follow-through
    apply(0,0,0,4'h0,4'b1010,4'hF,4'hF,4'h0,4'h0,"R2");
    apply(0,0,0,4'h0,4'b0101,4'hF,4'hF,4'h0,4'h0,"R2");
    apply(0,0,0,4'h0,4'b0011,4'hF,4'hF,4'h0,4'h0,"R2");
    // R3 inversion on registered cells
    apply(0,0,0,4'h0,4'b0011,4'hF,4'hF,4'hF,4'h0,"R3");
    // R5 / R11 set over data; R7 inverted pins go low
    apply(0,1,0,4'h0,4'h0,4'hF,4'hF,4'hF,4'h0,"R5");
    apply(0,0,0,4'h0,4'h0,4'hF,4'hF,4'hF,4'h0,"R7");
    // R6 async clear seen before any edge; R7 inverted pins go high
    apply(1,0,0,4'h0,4'hF,4'hF,4'hF,4'hF,4'h0,"R6");
    apply(0,0,0,4'h0,4'hF,4'hF,4'hF,4'b0101,4'h0,"R7");
    // R8 preload over set and data
    apply(0,1,1,4'b0110,4'b1001,4'hF,4'hF,4'h0,4'h0,"R8");
    apply(0,0,0,4'h0,4'h0,4'hF,4'hF,4'h0,4'h0,"R8");
    // R6 reset over preload
    apply(1,1,1,4'hF,4'hF,4'hF,4'hF,4'h0,4'h0,"R6");
    apply(0,0,0,4'h0,4'h0,4'hF,4'hF,4'h0,4'h0,"R6");
    // R1 / R3 combinational with mixed polarity
    apply(0,0,0,4'h0,4'b1100,4'hF,4'h0,4'b0101,4'h0,"R1");
    apply(0,0,0,4'h0,4'b0110,4'hF,4'h0,4'b0101,4'h0,"R1");
    apply(0,0,0,4'h0,4'b1111,4'hF,4'h0,4'h0,4'h0,"R3");
    // R4 / R10 disabled combinational pins read the outside level
    apply(0,0,0,4'h0,4'b0000,4'b0011,4'h0,4'h0,4'b1100,"R10");
    apply(0,0,0,4'h0,4'b1111,4'b0101,4'h0,4'h0,4'b1010,"R4");
    // R9 mixed modes: registered feedback ignores enable and polarity
    apply(0,0,0,4'h0,4'b1010,4'b0000,4'b1010,4'b1111,4'b0101,"R9");
    apply(0,0,0,4'h0,4'b0000,4'b0110,4'b1010,4'b0011,4'b1111,"R9");
    // R11 shared set across mixed modes
    apply(0,1,0,4'h0,4'b0000,4'hF,4'b0011,4'b0001,4'h0,"R11");
    apply(0,0,0,4'h0,4'b0000,4'hF,4'b0011,4'b0001,4'h0,"R11");
    @(negedge clk);
    @(negedge clk);
    #4;
    cmp("R2", "queue", N'(sb.size()), '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule